// File: doc/BRIEF.md
# Synchronous-to-Asynchronous SRAM Controller

This block sits between a synchronous request port and an asynchronous static RAM. It takes one request at a time: a word address, write data, byte-lane strobes and a read/write flag, accepted on a valid/ready handshake. It then plays out a fixed sequence of chip-select, output-enable, write-enable and lane-enable levels on the memory pins. Each phase of that sequence lasts a whole number of clock cycles. The phase lengths are derived at elaboration time from nanosecond timing parameters and a clock-period parameter. Each count is the ceiling of the time divided by the period, with a floor of one cycle.

A read keeps chip select, output enable and the requested lanes active for the access count. The memory data is registered on the last cycle of that count. A one-cycle read-valid pulse follows. A write proceeds in phases:

- A turn-around phase with only chip select active, so the memory's outputs have released the shared bus.
- A write-enable pulse with the data driver on.
- A hold phase with the driver still on.

After every operation the controller spends one cycle with all strobes inactive before it accepts the next request. The address register is loaded only on acceptance, so the address never changes while a strobe is active.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Out of reset and while no request is pending, `reqReady` is 1, `memCeN`, `memOeN` and `memWeN` are 1, every `memBeN` bit is 1, `memDqOe` is 0 and `rdValid` is 0.
- R2: A read holds `memCeN` and `memOeN` low for exactly RD cycles, where RD is the ceiling of the largest of read cycle time, address access time and output-enable access time over the clock period (6 at the defaults). `rdValid` is high for one cycle, RD clock edges after acceptance.
- R3: A write holds `memWeN` low for exactly WP cycles (5 at the defaults), with `memDqOe` high throughout. `memBeN[i]` is low only for lanes whose `reqBe[i]` was 1; lane i covers data bits 8i+7 down to 8i. A lane whose strobe bit is 0 is left unchanged in the memory.
- R4: `memDqOe` is never high while `memOeN` is low. When `memDqOe` rises, `memOeN` has been high for at least TURN preceding cycles, TURN being the ceiling of the 20 ns output-disable time over the period (2 at the defaults).
- R5: `memAddr` changes only at an edge before which `memCeN`, `memOeN` and `memWeN` were all 1 and every `memBeN` bit was 1.
- R6: After `memWeN` rises, the data driver stays on with unchanged data for at least one cycle.
- R7: Each operation ends with one cycle in which all strobes are inactive and `reqReady` is 0. `reqReady` returns 7 edges after a read is accepted and 9 edges after a write is accepted, at the defaults.
- R8: `memOeN` and `memWeN` are never low together.
- R9: In `rdData`, lanes whose read strobe bit was 1 carry the memory data captured on the last access cycle; the other lanes read as zero.
- R10: Data written through the controller reads back through it, merged byte by byte with earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted when valid is also high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte-lane strobes, bit i selects bits 8i+7:8i |
| rdValid | output | 1 | One-cycle pulse, `rdData` valid |
| rdData | output | DATA_W | Captured read data, unselected lanes zero |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBeN | output | DATA_W/8 | Byte-lane enables, active low |
| memDqOut | output | DATA_W | Write data toward the bus |
| memDqOe | output | 1 | Bus driver enable for `memDqOut` |
| memDqIn | input | DATA_W | Data from the bus |

## Verification
Directed cases cover the following, each separating a different fault:

- Full-word writes followed by reads, which expose phase-length errors.
- Single-lane writes and reads, which expose lane-to-bit mapping and masking faults.
- A write with no lanes selected, which exposes a controller that writes regardless of strobes.
- A write immediately after a read, which exposes a missing bus turn-around.

Seeded random mixes of reads and writes over a small address window then repeatedly hit the same words. A bench-side shadow memory catches lost or misplaced byte merges. A pin monitor measures every strobe pulse length, address change and driver enable against the computed cycle counts.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef struct packed {
    logic chipOn;
    logic outOn;
    logic writeOn;
    logic laneOn;
    logic drive;
    logic capture;
  } strobeT;

  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl_fsm.sv
module sram_seq_ctrl_fsm
  import sram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_HZ_NS = 20,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_CW_NS = 50,
  parameter int T_BW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_WR_NS = 0,
  parameter int T_DH_NS = 0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output logic   accept,
  output logic   rdValid,
  output strobeT strobes
);

  localparam int RD_CYC   = cyclesFor(maxOf(maxOf(T_RC_NS, T_AA_NS), T_OE_NS), CLK_PERIOD_NS);
  localparam int TURN_CYC = cyclesFor(T_HZ_NS, CLK_PERIOD_NS);
  localparam int WP_CYC   = maxOf(cyclesFor(maxOf(maxOf(T_WP_NS, T_DW_NS), T_BW_NS), CLK_PERIOD_NS),
                                  cyclesFor(maxOf(T_AW_NS, T_CW_NS), CLK_PERIOD_NS) - TURN_CYC);
  localparam int HOLD_CYC = maxOf(cyclesFor(maxOf(T_WR_NS, T_DH_NS), CLK_PERIOD_NS),
                                  cyclesFor(T_WC_NS, CLK_PERIOD_NS) - TURN_CYC - WP_CYC);
  localparam int MAX_CYC  = maxOf(maxOf(RD_CYC, TURN_CYC), maxOf(WP_CYC, HOLD_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ACCESS, S_RD_DONE, S_WR_SETUP, S_WR_PULSE, S_WR_HOLD, S_WR_DONE
  } stateT;

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic             rdValidQ;
  logic             cntZero;

  assign cntZero  = (cnt == '0);
  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid && reqReady;
  assign rdValid  = rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (reqWrite) begin
              state <= S_WR_SETUP;
              cnt   <= TURN_LOAD;
            end else begin
              state <= S_RD_ACCESS;
              cnt   <= RD_LOAD;
            end
          end
        end
        S_RD_ACCESS: begin
          if (cntZero) begin
            state    <= S_RD_DONE;
            rdValidQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RD_DONE: state <= S_IDLE;
        S_WR_SETUP: begin
          if (cntZero) begin
            state <= S_WR_PULSE;
            cnt   <= WP_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WR_PULSE: begin
          if (cntZero) begin
            state <= S_WR_HOLD;
            cnt   <= HOLD_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WR_HOLD: begin
          if (cntZero) state <= S_WR_DONE;
          else         cnt   <= cnt - 1'b1;
        end
        S_WR_DONE: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    case (state)
      S_RD_ACCESS: begin
        strobes.chipOn  = 1'b1;
        strobes.outOn   = 1'b1;
        strobes.laneOn  = 1'b1;
        strobes.capture = cntZero;
      end
      S_WR_SETUP: strobes.chipOn = 1'b1;
      S_WR_PULSE: begin
        strobes.chipOn  = 1'b1;
        strobes.writeOn = 1'b1;
        strobes.laneOn  = 1'b1;
        strobes.drive   = 1'b1;
      end
      S_WR_HOLD: begin
        strobes.chipOn = 1'b1;
        strobes.laneOn = 1'b1;
        strobes.drive  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // Checker state: consecutive cycles with output enable released, saturating
  logic [CNT_W-1:0] oeOffRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeOffRun <= '0;
    else if (strobes.outOn) oeOffRun <= '0;
    else if (int'(oeOffRun) < TURN_CYC) oeOffRun <= oeOffRun + 1'b1;
  end

  a_r4_turn_around: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.drive) |-> (int'(oeOffRun) >= TURN_CYC));

  a_r2_read_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r7_gap_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accept,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqBe,
  input  strobeT                 strobes,
  input  logic [DATA_W-1:0]      memDqIn,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memCeN,
  output logic                   memOeN,
  output logic                   memWeN,
  output logic [DATA_W/8-1:0]    memBeN,
  output logic [DATA_W-1:0]      memDqOut,
  output logic                   memDqOe,
  output logic [DATA_W-1:0]      rdData
);

  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] rdMasked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign rdMasked[lane*8 +: 8] = beQ[lane] ? memDqIn[lane*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdDataQ <= '0;
    else if (strobes.capture) rdDataQ <= rdMasked;
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memCeN   = ~strobes.chipOn;
  assign memOeN   = ~strobes.outOn;
  assign memWeN   = ~strobes.writeOn;
  assign memBeN   = strobes.laneOn ? ~beQ : {BE_W{1'b1}};
  assign memDqOe  = strobes.drive;
  assign rdData   = rdDataQ;

  logic allOff;
  assign allOff = memCeN && memOeN && memWeN && (&memBeN);

  a_r5_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> $past(allOff));

  a_r8_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  a_r3_drive_during_we: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOe);

  a_r6_hold_after_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && $stable(memDqOut)));

  a_r4_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_HZ_NS = 20,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_CW_NS = 50,
  parameter int T_BW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_WR_NS = 0,
  parameter int T_DH_NS = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W/8-1:0]  reqBe,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memCeN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic [DATA_W/8-1:0]  memBeN,
  output logic [DATA_W-1:0]    memDqOut,
  output logic                 memDqOe,
  input  logic [DATA_W-1:0]    memDqIn
);

  strobeT strobes;
  logic   accept;

  sram_seq_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS), .T_CW_NS(T_CW_NS), .T_BW_NS(T_BW_NS), .T_DW_NS(T_DW_NS),
    .T_WR_NS(T_WR_NS), .T_DH_NS(T_DH_NS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .accept(accept), .rdValid(rdValid), .strobes(strobes)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .accept(accept), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .strobes(strobes), .memDqIn(memDqIn),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .rdData(rdData)
  );

endmodule

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb_top;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int RD_CYC = 6;
  localparam int TURN_CYC = 2;
  localparam int WP_CYC = 5;
  localparam int RD_LAT = 7;
  localparam int WR_LAT = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0]    reqBe = '0;
  logic          rdValid;
  logic [DW-1:0] rdData;
  logic [AW-1:0] memAddr;
  logic          memCeN, memOeN, memWeN, memDqOe;
  logic [1:0]    memBeN;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn;

  int total = 0;
  int failed = 0;
  int cycles = 0;

  logic [DW-1:0] ram    [1024];
  logic [DW-1:0] shadow [1024];

  always #5 clk = ~clk;

  sram_seq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Memory model: drives only when selected for read, unselected lanes read 8'hA5
  always_comb begin
    memDqIn = 16'hFFFF;
    if (!memCeN && !memOeN && memWeN) begin
      for (int l = 0; l < 2; l++)
        memDqIn[l*8 +: 8] = memBeN[l] ? 8'hA5 : ram[memAddr][l*8 +: 8];
    end
  end

  always @(posedge clk) begin
    if (!memCeN && !memWeN && memDqOe) begin
      for (int l = 0; l < 2; l++)
        if (!memBeN[l]) ram[memAddr][l*8 +: 8] <= memDqOut[l*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  function automatic logic [DW-1:0] expRead(input logic [DW-1:0] word, input logic [1:0] be);
    logic [DW-1:0] r;
    r[7:0]  = be[0] ? word[7:0]  : 8'h00;
    r[15:8] = be[1] ? word[15:8] : 8'h00;
    return r;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [1:0] be);
    logic [DW-1:0] r;
    r[7:0]  = be[0] ? d[7:0]  : old[7:0];
    r[15:8] = be[1] ? d[15:8] : old[15:8];
    return r;
  endfunction

  // Pin monitor
  logic [AW-1:0] prevAddr = '0;
  bit  prevAllOff = 1'b1;
  bit  prevDrive = 1'b0;
  int  weRun = 0, oeRun = 0, oeOffRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (memAddr != prevAddr) check(prevAllOff, "R5 addr change with strobe active", 0, 1);
      if (!memOeN && !memWeN) check(0, "R8 oe and we both low", 1, 0);
      if (memDqOe && !memOeN) check(0, "R4 drive while oe low", 1, 0);
      if (memDqOe && !prevDrive) check(oeOffRun >= TURN_CYC, "R4 turn-around", oeOffRun, TURN_CYC);
      if (!memWeN) weRun++;
      else if (weRun != 0) begin
        check(weRun == WP_CYC, "R3 we pulse length", weRun, WP_CYC);
        check(memDqOe, "R6 data held after we", memDqOe, 1);
        weRun = 0;
      end
      if (!memOeN) oeRun++;
      else if (oeRun != 0) begin
        check(oeRun == RD_CYC, "R2 oe pulse length", oeRun, RD_CYC);
        oeRun = 0;
      end
      oeOffRun = memOeN ? oeOffRun + 1 : 0;
      prevAddr   = memAddr;
      prevAllOff = memCeN && memOeN && memWeN && (&memBeN);
      prevDrive  = memDqOe;
    end
  end

  initial begin
    wait (cycles > 100000);
    check(0, "watchdog", cycles, 100000);
    summary();
  end

  task automatic checkIdle(input string req);
    check(reqReady == 1'b1, {req, " ready"}, reqReady, 1);
    check({memCeN, memOeN, memWeN, memBeN} == 5'b11111, {req, " strobes"},
          {memCeN, memOeN, memWeN, memBeN}, 5'h1f);
    check(memDqOe == 1'b0, {req, " driver"}, memDqOe, 0);
    check(rdValid == 1'b0, {req, " rdValid"}, rdValid, 0);
  endtask

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] be);
    int lat;
    int rdLat;
    logic [DW-1:0] got;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = ~d;
    lat = 0; rdLat = -1; got = '0;
    while (!reqReady && lat < 50) begin
      if (rdValid) begin
        rdLat = lat;
        got = rdData;
        check(!reqReady, "R7 ready low with rdValid", reqReady, 0);
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    if (wr) begin
      check(lat == WR_LAT, "R7 write ready latency", lat, WR_LAT);
      check(rdLat == -1, "R2 no rdValid on write", rdLat, -1);
      shadow[a] = merge(shadow[a], d, be);
    end else begin
      check(lat == RD_LAT, "R7 read ready latency", lat, RD_LAT);
      check(rdLat == RD_CYC, "R2 rdValid timing", rdLat, RD_CYC);
      check(got == expRead(shadow[a], be), "R9/R10 read data", got, expRead(shadow[a], be));
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ram[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    checkIdle("R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1 after reset");

    // R10 full-word write and readback
    doOp(1'b1, 10'd5, 16'h1234, 2'b11);
    doOp(1'b0, 10'd5, 16'h0000, 2'b11);
    // R3 lane 0 only, then lane 1 only: merge
    doOp(1'b1, 10'd5, 16'hAB_CD, 2'b01);
    doOp(1'b0, 10'd5, 16'h0000, 2'b11);
    doOp(1'b1, 10'd5, 16'hEF_00, 2'b10);
    doOp(1'b0, 10'd5, 16'h0000, 2'b11);
    // R3 no lanes selected leaves word unchanged
    doOp(1'b1, 10'd5, 16'h5555, 2'b00);
    doOp(1'b0, 10'd5, 16'h0000, 2'b11);
    // R9 lane masking on reads
    doOp(1'b0, 10'd5, 16'h0000, 2'b01);
    doOp(1'b0, 10'd5, 16'h0000, 2'b10);
    doOp(1'b0, 10'd5, 16'h0000, 2'b00);
    // Top address, then read immediately followed by write (R4 turn-around)
    doOp(1'b1, 10'h3FF, 16'hFACE, 2'b11);
    doOp(1'b0, 10'h3FF, 16'h0000, 2'b11);
    doOp(1'b1, 10'h3FF, 16'h0F0F, 2'b10);
    doOp(1'b0, 10'h3FF, 16'h0000, 2'b11);
    // R1 idle with no request
    repeat (4) @(negedge clk);
    checkIdle("R1 idle");

    void'($urandom(32'd2024));
    for (int n = 0; n < 300; n++) begin
      bit wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [1:0] be;
      wr = 1'($urandom % 2);
      a  = AW'($urandom % 16);
      d  = DW'($urandom);
      be = 2'($urandom % 4);
      doOp(wr, a, d, be);
      if (($urandom % 4) == 0) repeat (2) @(negedge clk);
    end
    // Final sweep of the random window
    for (int a = 0; a < 16; a++) doOp(1'b0, AW'(a), 16'h0000, 2'b11);
    @(negedge clk);
    checkIdle("R1 end");
    summary();
  end

endmodule